// File: doc/BRIEF.md
# Data-Strobe Link Character Receiver

This block turns a Data-Strobe line pair into a stream of link characters. It oversamples the two lines with the system clock and takes one bit each time the exclusive-or of data and strobe changes. It frames the bits into 4-bit control characters and 10-bit data characters. It checks odd parity across character boundaries and pairs escape characters with the character that follows them. It then hands normal characters (data, end of packet, error end of packet) to a receive buffer through a one-cycle write strobe.

Flow control runs on credit. The block counts how many normal characters the far end may still send. That count rises by eight each time the local transmitter reports that it has sent a flow-control token, and it falls by one for each character written. From this count and the free space in the buffer, the block drives a level that asks the transmitter for another token. It also drives a pulse for each flow-control token that arrives from the far end. Time codes are reported as a 6-bit value with two flag bits.

Each link error is sticky and freezes decoding until reset: parity error, escape error, credit error and line silence (disconnect).

Top module: `ds_link_rx`

## Requirements
- R1: One bit is accepted each time din xor sin changes value, and the accepted bit value is din. Characters are sent LSB first.
- R2: Each character begins with a parity bit and then a flag bit. A flag of 0 is followed by 8 data bits. A flag of 1 is followed by two code bits (first, second): FCT (0,0), EOP (0,1), EEP (1,0), ESC (1,1).
- R3: After reset, every character is ignored until an ESC immediately followed by an FCT (a NULL) is received. That NULL sets got_null high, and got_null then stays high until reset.
- R4: got_fct pulses high for one clock for each FCT that is not the second half of a NULL.
- R5: Each data character is written with wr_en high for one clock and wr_data = {1'b0, byte}. EOP is written as 9'h100 and EEP as 9'h101. NULL, FCT and time codes are never written.
- R6: An ESC followed by a data character is a time code. time_valid pulses for one clock, with time_val = byte[5:0] and time_flags = byte[7:6]. The credit count is unchanged.
- R7: The outstanding credit count starts at 0. It rises by 8 on each clock with tx_fct_sent high and falls by 1 for each written character.
- R8: need_fct is high exactly when the outstanding count is at most 48 and buf_free is at least the outstanding count plus 8.
- R9: A normal character that arrives while the outstanding count is 0 sets crd_err and is not written.
- R10: An ESC followed by ESC, EOP or EEP sets esc_err.
- R11: Parity is odd over the previous character's data or code bits plus the current parity and flag bits. A mismatch sets par_err.
- R12: par_err, esc_err, crd_err and discon stay high until reset. While any of them is high, no character produces a write, a got_fct pulse or a time code.
- R13: Once the first bit has arrived, discon is set if no bit is accepted for discon_limit+1 clocks. It is not set while bits keep arriving within discon_limit clocks of each other.
- R14: Reset clears got_null, all error flags, all pulses and the outstanding count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Data line |
| sin | input | 1 | Strobe line |
| tx_fct_sent | input | 1 | Pulse: the local transmitter sent one FCT |
| buf_free | input | BUF_W | Free entries in the receive buffer |
| discon_limit | input | LIM_W | Silence limit in clocks (about 43 at 50 MHz for 850 ns) |
| wr_en | output | 1 | Write strobe toward the receive buffer |
| wr_data | output | 9 | Buffer word: bit 8 marks a packet end, bits 7:0 hold the byte |
| got_fct | output | 1 | Pulse for each received FCT |
| need_fct | output | 1 | Level: the transmitter may grant eight more characters |
| got_null | output | 1 | First NULL has been received |
| time_valid | output | 1 | Pulse: a time code was received |
| time_val | output | 6 | Received time value |
| time_flags | output | 2 | Received time control flags |
| par_err | output | 1 | Sticky parity error |
| esc_err | output | 1 | Sticky escape-sequence error |
| crd_err | output | 1 | Sticky credit error |
| discon | output | 1 | Sticky disconnect (line silence) |

## Verification
On every cycle the assertions check the following. A write never happens without prior credit. got_fct never fires before the first NULL, and never in the same cycle as a write. par_err never clears. The credit count stays within 56. Time-code pulses are isolated, and a frozen receiver stays silent. The bench scenarios cover what depends on the bit stream itself: the bit recovery and the mapping of the code bits, the contents of each buffer word, and how a time byte splits into value and flags. They also cover the exact credit thresholds behind need_fct, characters being ignored before the first NULL, and the disconnect timeout relative to the gaps between bits.

// File: rtl/ds_link_rx.sv
module ds_link_rx #(
  parameter int BUF_W = 7,
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic             sin,
  input  logic             tx_fct_sent,
  input  logic [BUF_W-1:0] buf_free,
  input  logic [LIM_W-1:0] discon_limit,
  output logic             wr_en,
  output logic [8:0]       wr_data,
  output logic             got_fct,
  output logic             need_fct,
  output logic             got_null,
  output logic             time_valid,
  output logic [5:0]       time_val,
  output logic [1:0]       time_flags,
  output logic             par_err,
  output logic             esc_err,
  output logic             crd_err,
  output logic             discon
);
  localparam int CW       = 6;
  localparam int GRANT    = 8;
  localparam int CAP      = 7 * GRANT;
  localparam int NEED_MAX = CAP - GRANT;

  logic [2:0] dq, sq;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dq <= '0;
      sq <= '0;
    end else begin
      dq <= {dq[1:0], din};
      sq <= {sq[1:0], sin};
    end

  wire bit_stb = (dq[1] ^ sq[1]) != (dq[2] ^ sq[2]);
  wire halted  = par_err | esc_err | crd_err | discon;
  wire take    = bit_stb && !halted;

  logic [9:0] chr, chr_n;
  logic [3:0] pos;
  logic       pacc;
  always_comb begin
    chr_n      = chr;
    chr_n[pos] = dq[1];
  end

  wire       is_ctl  = chr_n[1];
  wire       par_bad = take && pos == 4'd1 && !(pacc ^ chr_n[0] ^ chr_n[1]);
  wire       done    = take && ((pos == 4'd3 && is_ctl) || pos == 4'd9);
  wire [1:0] code    = chr_n[3:2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      chr  <= '0;
      pos  <= '0;
      pacc <= 1'b0;
    end else if (take) begin
      chr <= chr_n;
      if (done) begin
        pos  <= '0;
        pacc <= is_ctl ? ^chr_n[3:2] : ^chr_n[9:2];
      end else begin
        pos <= pos + 4'd1;
      end
    end

  logic          esc_pend;
  logic [CW-1:0] outstanding, out_nx;

  wire c_fct     = done && is_ctl && code == 2'b00;
  wire c_esc     = done && is_ctl && code == 2'b11;
  wire c_end     = done && is_ctl && (code == 2'b10 || code == 2'b01);
  wire c_dat     = done && !is_ctl;
  wire nul       = c_fct && esc_pend;
  wire fct_plain = c_fct && !esc_pend && got_null;
  wire tcode     = c_dat && esc_pend && got_null;
  wire nchar     = (c_dat || c_end) && !esc_pend && got_null;
  wire bad_esc   = (c_esc || c_end) && esc_pend && got_null;
  wire wr_ok     = nchar && outstanding != '0;
  wire no_credit = nchar && outstanding == '0;

  always_comb begin
    out_nx = outstanding;
    if (tx_fct_sent) out_nx = out_nx + CW'(GRANT);
    if (wr_ok)       out_nx = out_nx - 1'b1;
  end

  assign need_fct = (int'(outstanding) <= NEED_MAX) &&
                    (int'(buf_free) >= int'(outstanding) + GRANT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      esc_pend    <= 1'b0;
      outstanding <= '0;
      got_null    <= 1'b0;
      got_fct     <= 1'b0;
      wr_en       <= 1'b0;
      wr_data     <= '0;
      time_valid  <= 1'b0;
      time_val    <= '0;
      time_flags  <= '0;
      par_err     <= 1'b0;
      esc_err     <= 1'b0;
      crd_err     <= 1'b0;
    end else begin
      if (done) esc_pend <= c_esc;
      outstanding <= out_nx;
      if (nul) got_null <= 1'b1;
      got_fct    <= fct_plain;
      wr_en      <= wr_ok;
      time_valid <= tcode;
      if (wr_ok) wr_data <= c_dat ? {1'b0, chr_n[9:2]} : {1'b1, 7'd0, code == 2'b01};
      if (tcode) {time_flags, time_val} <= chr_n[9:2];
      par_err <= par_err | par_bad;
      esc_err <= esc_err | bad_esc;
      crd_err <= crd_err | no_credit;
    end

  logic             armed;
  logic [LIM_W-1:0] idle;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed  <= 1'b0;
      idle   <= '0;
      discon <= 1'b0;
    end else if (bit_stb) begin
      armed <= 1'b1;
      idle  <= '0;
    end else if (armed && !discon) begin
      if (idle == discon_limit) discon <= 1'b1;
      else                      idle   <= idle + 1'b1;
    end

  // R5 R9
  wr_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(outstanding) != '0);
  // R3 R4
  fct_after_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    got_fct |-> got_null);
  // R4 R5
  wr_fct_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && got_fct));
  // R12
  par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> par_err);
  // R12
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halted) |-> !wr_en && !got_fct && !time_valid);
  // R7
  credit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(outstanding) <= CAP);
  // R6
  time_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    time_valid |=> !time_valid);
endmodule

// File: tb/ds_link_rx_tb.sv
module ds_link_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       d_l = 1'b0, s_l = 1'b0;
  logic       tx_fct = 1'b0;
  logic [6:0] buf_free = 7'd16;
  logic [7:0] lim = 8'd20;
  logic       wr_en, got_fct, need_fct, got_null, time_valid;
  logic       par_err, esc_err, crd_err, discon;
  logic [8:0] wr_data;
  logic [5:0] time_val;
  logic [1:0] time_flags;

  int   vectors = 0, miscompares = 0;
  int   wr_n = 0, fct_n = 0, tv_n = 0;
  logic [8:0] wr_log [0:31];
  logic       bpar = 1'b0;

  always #10 clk = ~clk;

  ds_link_rx u_dut (
    .clk(clk), .rst_n(rst_n), .din(d_l), .sin(s_l), .tx_fct_sent(tx_fct),
    .buf_free(buf_free), .discon_limit(lim), .wr_en(wr_en), .wr_data(wr_data),
    .got_fct(got_fct), .need_fct(need_fct), .got_null(got_null),
    .time_valid(time_valid), .time_val(time_val), .time_flags(time_flags),
    .par_err(par_err), .esc_err(esc_err), .crd_err(crd_err), .discon(discon));

  always @(negedge clk)
    if (rst_n) begin
      if (wr_en) begin
        if (wr_n < 32) wr_log[wr_n] = wr_data;
        wr_n++;
      end
      if (got_fct) fct_n++;
      if (time_valid) tv_n++;
    end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    if (b != d_l) d_l = b;
    else          s_l = ~s_l;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_ctl(input logic c2, input logic c3, input logic bad = 1'b0);
    send_bit(bpar ^ bad);
    send_bit(1'b1);
    send_bit(c2);
    send_bit(c3);
    bpar = c2 ^ c3;
  endtask

  task automatic send_dat(input logic [7:0] v);
    send_bit(~bpar);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
    bpar = ^v;
  endtask

  task automatic fct();  send_ctl(1'b0, 1'b0); endtask
  task automatic eop();  send_ctl(1'b0, 1'b1); endtask
  task automatic eep();  send_ctl(1'b1, 1'b0); endtask
  task automatic esc();  send_ctl(1'b1, 1'b1); endtask
  task automatic null_c(); esc(); fct(); endtask
  task automatic settle(); repeat (4) @(negedge clk); endtask

  task automatic grant(input int n);
    for (int i = 0; i < n; i++) begin
      tx_fct = 1'b1;
      @(negedge clk);
      tx_fct = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    d_l = 1'b0; s_l = 1'b0; bpar = 1'b0; tx_fct = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wr_n = 0; fct_n = 0; tv_n = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    buf_free = 7'd16;
    chk("R14 wr_en", wr_en, 0);
    chk("R14 got_null", got_null, 0);
    chk("R14 errors", {par_err, esc_err, crd_err, discon}, 0);
    chk("R8 need at 0 credit, 16 free", need_fct, 1);
    buf_free = 7'd7;
    @(negedge clk);
    chk("R8 need at 0 credit, 7 free", need_fct, 0);
    repeat (40) @(negedge clk);
    chk("R13 no discon before first bit", discon, 0);
  endtask

  task automatic t_prenull();
    do_reset();
    fct(); send_dat(8'h55); eop(); settle();
    chk("R3 no fct before null", fct_n, 0);
    chk("R3 no write before null", wr_n, 0);
    chk("R3 got_null low", got_null, 0);
    null_c(); settle();
    chk("R3 got_null after NULL", got_null, 1);
    chk("R4 NULL gives no got_fct", fct_n, 0);
  endtask

  task automatic t_flow();
    fct(); fct(); settle();
    chk("R4 two fct pulses", fct_n, 2);
    grant(1);
    buf_free = 7'd16; @(negedge clk);
    chk("R7 R8 need at credit 8, 16 free", need_fct, 1);
    buf_free = 7'd15; @(negedge clk);
    chk("R7 R8 need at credit 8, 15 free", need_fct, 0);
    send_dat(8'hA3); send_dat(8'h0F); eop(); eep(); null_c(); send_dat(8'hFF); settle();
    chk("R5 write count", wr_n, 5);
    chk("R1 R5 word0", wr_log[0], 9'h0A3);
    chk("R1 R5 word1", wr_log[1], 9'h00F);
    chk("R2 R5 EOP word", wr_log[2], 9'h100);
    chk("R2 R5 EEP word", wr_log[3], 9'h101);
    chk("R5 word4", wr_log[4], 9'h0FF);
    chk("R11 no parity error", par_err, 0);
    chk("R9 no credit error", crd_err, 0);
    buf_free = 7'd11; @(negedge clk);
    chk("R7 need at credit 3, 11 free", need_fct, 1);
    buf_free = 7'd10; @(negedge clk);
    chk("R7 need at credit 3, 10 free", need_fct, 0);
  endtask

  task automatic t_time();
    esc(); send_dat(8'hAD); settle();
    chk("R6 time pulse", tv_n, 1);
    chk("R6 time value", time_val, 6'h2D);
    chk("R6 time flags", time_flags, 2);
    chk("R6 no write", wr_n, 5);
    buf_free = 7'd11; @(negedge clk);
    chk("R6 credit unchanged", need_fct, 1);
  endtask

  task automatic t_limit();
    do_reset();
    null_c(); settle();
    buf_free = 7'd127;
    grant(6);
    chk("R8 need at credit 48", need_fct, 1);
    grant(1);
    chk("R8 need at credit 56", need_fct, 0);
  endtask

  task automatic t_credit();
    do_reset();
    null_c(); send_dat(8'h12); settle();
    chk("R9 crd_err", crd_err, 1);
    chk("R9 nothing written", wr_n, 0);
    grant(1);
    fct(); send_dat(8'h34); settle();
    chk("R12 halted: no fct", fct_n, 0);
    chk("R12 halted: no write", wr_n, 0);
    chk("R12 crd_err sticky", crd_err, 1);
  endtask

  task automatic t_escape();
    do_reset();
    null_c(); esc(); eop(); settle();
    chk("R10 esc then eop", esc_err, 1);
    do_reset();
    null_c(); esc(); esc(); settle();
    chk("R10 esc then esc", esc_err, 1);
    do_reset();
    null_c(); null_c(); settle();
    chk("R10 null pair ok", esc_err, 0);
  endtask

  task automatic t_parity();
    do_reset();
    null_c(); fct(); settle();
    chk("R11 good parity", par_err, 0);
    send_ctl(1'b0, 1'b0, 1'b1); settle();
    chk("R11 bad parity flagged", par_err, 1);
    chk("R11 bad fct not counted", fct_n, 1);
    bpar = 1'b0;
    fct(); settle();
    chk("R12 ignored after parity error", fct_n, 1);
  endtask

  task automatic t_discon();
    do_reset();
    null_c(); fct(); fct();
    chk("R13 no discon with traffic", discon, 0);
    repeat (40) @(negedge clk);
    chk("R13 discon after silence", discon, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_prenull();
    t_flow();
    t_time();
    t_limit();
    t_credit();
    t_escape();
    t_parity();
    t_discon();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule